// File: doc/BRIEF.md
# GPIO Port Controller with Per-Pin Function Select

This block manages one bank of general-purpose pins, up to sixteen of them. Each pin has a 4-bit function code. The code decides whether the pin floats as an input, drives the level held in an output latch, or passes through the output and output-enable of an alternate peripheral function. Software reaches the function codes and the data bits over a small synchronous register bus. Writes take effect on the clock edge. Reads return the addressed word combinationally.

The register map depends on the bank width, fixed at build time. A bank of eight pins or fewer has one function word, followed by the data word. A wider bank has two function words, with the data word placed after the second one.

Pad levels pass through a two-stage synchroniser before they can be read. The output latch keeps its value while its pin is not an output. Software can therefore load a level first and switch the pin to output afterwards, and the pin drives that level from its first driven cycle.

Top module: `pin_mux_port`

## Requirements
- R1: After reset, every function code and every output latch bit is 0, so every pad has output 0 and output enable 0.
- R2: The function code of pin n sits in bits 4*(n mod 8)+3 down to 4*(n mod 8) of function word n/8. A write to a function word updates those fields, and a read returns them.
- R3: Code 0 puts the pin in input mode, and its output enable is 0.
- R4: Code 1 puts the pin in output mode. Its output enable is 1 and its output equals its latch bit.
- R5: Code 2+k, for k below NUM_ALT, routes alternate function k to the pin: output from alt_out[k*NUM_PINS+n] and enable from alt_oe[k*NUM_PINS+n]. Any other code leaves the pin with output 0 and output enable 0.
- R6: The byte offsets depend on the bank width. With NUM_PINS of 8 or less, 0x00 holds the function word and 0x04 the data word. With NUM_PINS above 8, 0x00 holds pins 0-7, 0x04 holds pins 8-15 and 0x08 holds the data word.
- R7: A write to the data word loads the latch of every pin, whatever its mode, and nothing else changes the latch. A pin switched to output drives the preloaded level in the same cycle its enable rises.
- R8: Data word bit n reads the latch when pin n is in output mode, and otherwise reads the synchronised pad level.
- R9: A change on pad_in is visible in the data word after exactly two rising clock edges.
- R10: Reads of an offset outside the map return 0, and writes to such an offset change no register.
- R11: Function fields of pins at or above NUM_PINS, and data bits at or above NUM_PINS, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when 1 (with bus_sel) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| alt_out | input | NUM_ALT*NUM_PINS | Alternate function outputs, function k at k*NUM_PINS+n |
| alt_oe | input | NUM_ALT*NUM_PINS | Alternate function output enables, same layout |
| pad_out | output | NUM_PINS | Level driven toward each pad |
| pad_oe | output | NUM_PINS | Output enable for each pad |

## Verification
The bench builds two instances side by side. The first is a 16-pin bank with three alternate functions, which exercises the two-word layout, the data word at 0x08 and codes that select, or fail to select, a function. The second is a 6-pin bank with one alternate function, which exercises the single-word layout. On that instance, 0x08 becomes an unmapped offset, and the function fields of the missing pins 6 and 7 can be checked to read as zero. Function code 3 also becomes an unused code there, so it must leave its pin undriven.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  localparam int BUS_W   = 32;
  localparam int FIELD_W = 4;
  localparam int PINS_PER_WORD = BUS_W / FIELD_W;

  localparam logic [FIELD_W-1:0] CODE_INPUT  = 4'h0;
  localparam logic [FIELD_W-1:0] CODE_OUTPUT = 4'h1;
  localparam int                 CODE_ALT_BASE = 2;

  typedef enum logic [1:0] {
    MODE_INPUT  = 2'd0,
    MODE_OUTPUT = 2'd1,
    MODE_ALT    = 2'd2,
    MODE_FLOAT  = 2'd3
  } pin_mode_e;

  // Byte offset of the data word for a given bank width.
  function automatic int data_offset(input int num_pins);
    return (num_pins > PINS_PER_WORD) ? 8 : 4;
  endfunction

  // Byte offset of the function word that holds pin p.
  function automatic int cfg_offset(input int p);
    return (p / PINS_PER_WORD) * 4;
  endfunction

  // Mode selected by a function code when n_alt alternates exist.
  function automatic pin_mode_e classify(input logic [FIELD_W-1:0] code, input int n_alt);
    if (code == CODE_INPUT)  return MODE_INPUT;
    if (code == CODE_OUTPUT) return MODE_OUTPUT;
    if (int'(code) - CODE_ALT_BASE < n_alt) return MODE_ALT;
    return MODE_FLOAT;
  endfunction

endpackage

// File: rtl/pmp_sync.sv
module pmp_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/pmp_regfile.sv
module pmp_regfile
  import pmp_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BUS_W-1:0]            wdata,
  output logic [BUS_W-1:0]            rdata,
  input  logic [NUM_PINS-1:0]         sync_in,
  output logic [FIELD_W*NUM_PINS-1:0] cfg_flat,
  output logic [NUM_PINS-1:0]         latch_q,
  output logic                        data_wr
);

  localparam int NUM_WORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
  localparam logic [ADDR_W-1:0] DATA_OFF = ADDR_W'(data_offset(NUM_PINS));

  logic [FIELD_W-1:0] cfg_q [NUM_PINS];
  logic [NUM_WORDS-1:0] cfg_hit;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign data_wr = sel && wr && (addr == DATA_OFF);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign cfg_hit[w] = sel && wr && (addr == ADDR_W'(w * 4));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[p] <= CODE_INPUT;
      else if (cfg_hit[p / PINS_PER_WORD])
        cfg_q[p] <= wdata[FIELD_W*(p % PINS_PER_WORD) +: FIELD_W];
    end
    assign cfg_flat[FIELD_W*p +: FIELD_W] = cfg_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (data_wr) latch_q <= wdata[NUM_PINS-1:0];
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr == ADDR_W'(cfg_offset(p)))
        rdata[FIELD_W*(p % PINS_PER_WORD) +: FIELD_W] = cfg_q[p];
      if (addr == DATA_OFF)
        rdata[p] = (cfg_q[p] == CODE_OUTPUT) ? latch_q[p] : sync_in[p];
    end
  end

endmodule

// File: rtl/pmp_pin_mux.sv
module pmp_pin_mux
  import pmp_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_ALT  = 3
) (
  input  logic [FIELD_W*NUM_PINS-1:0] cfg_flat,
  input  logic [NUM_PINS-1:0]         latch_q,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_out,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe,
  output logic [NUM_PINS-1:0]         pad_out,
  output logic [NUM_PINS-1:0]         pad_oe
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [FIELD_W-1:0] code;
    pin_mode_e          mode;

    assign code = cfg_flat[FIELD_W*p +: FIELD_W];
    assign mode = classify(code, NUM_ALT);

    always_comb begin
      pad_out[p] = 1'b0;
      pad_oe[p]  = 1'b0;
      case (mode)
        MODE_OUTPUT: begin
          pad_out[p] = latch_q[p];
          pad_oe[p]  = 1'b1;
        end
        MODE_ALT: begin
          for (int k = 0; k < NUM_ALT; k++) begin
            if (int'(code) == k + CODE_ALT_BASE) begin
              pad_out[p] = alt_out[k*NUM_PINS + p];
              pad_oe[p]  = alt_oe[k*NUM_PINS + p];
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pin_mux_port.sv
module pin_mux_port
  import pmp_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_ALT  = 3,
  parameter int ADDR_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_PINS-1:0]         pad_in,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_out,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe,
  output logic [NUM_PINS-1:0]         pad_out,
  output logic [NUM_PINS-1:0]         pad_oe
);

  logic [NUM_PINS-1:0]         sync_q;
  logic [FIELD_W*NUM_PINS-1:0] cfg_flat;
  logic [NUM_PINS-1:0]         latch_q;
  logic                        data_wr;

  pmp_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (sync_q)
  );

  pmp_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_sel),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .sync_in  (sync_q),
    .cfg_flat (cfg_flat),
    .latch_q  (latch_q),
    .data_wr  (data_wr)
  );

  pmp_pin_mux #(.NUM_PINS(NUM_PINS), .NUM_ALT(NUM_ALT)) u_mux (
    .cfg_flat (cfg_flat),
    .latch_q  (latch_q),
    .alt_out  (alt_out),
    .alt_oe   (alt_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_ALT  = 3,
  parameter int ADDR_W   = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_sel,
  input logic                        bus_wr,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [31:0]                 bus_wdata,
  input logic [31:0]                 bus_rdata,
  input logic [NUM_PINS-1:0]         pad_in,
  input logic [NUM_PINS-1:0]         pad_out,
  input logic [NUM_PINS-1:0]         pad_oe,
  input logic [NUM_PINS-1:0]         sync_q,
  input logic [FIELD_W*NUM_PINS-1:0] cfg_flat,
  input logic [NUM_PINS-1:0]         latch_q,
  input logic                        data_wr
);

  localparam logic [ADDR_W-1:0] DATA_OFF = ADDR_W'(data_offset(NUM_PINS));

  logic [NUM_PINS-1:0] in_mask, out_mask, float_mask;
  logic                mapped;
  logic [1:0]          cyc;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      in_mask[p]    = cfg_flat[FIELD_W*p +: FIELD_W] == 4'h0;
      out_mask[p]   = cfg_flat[FIELD_W*p +: FIELD_W] == 4'h1;
      float_mask[p] = int'(cfg_flat[FIELD_W*p +: FIELD_W]) >= NUM_ALT + 2;
    end
  end

  assign mapped = (bus_addr == '0) || (bus_addr == DATA_OFF) ||
                  ((NUM_PINS > 8) && (bus_addr == ADDR_W'(4)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_INPUT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & in_mask) == '0); // R3

  AST_OUTPUT_DRIVES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & out_mask) == out_mask) && ((pad_out & out_mask) == (latch_q & out_mask))); // R4

  AST_UNUSED_CODE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & float_mask) == '0); // R5

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(latch_q)); // R7

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (sync_q == $past(pad_in, 2))); // R9

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == '0)); // R10

  AST_FIELD0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == '0) |=> (cfg_flat[3:0] == $past(bus_wdata[3:0]))); // R2

endmodule

bind pin_mux_port pmp_checker #(
  .NUM_PINS (NUM_PINS),
  .NUM_ALT  (NUM_ALT),
  .ADDR_W   (ADDR_W)
) u_pmp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .sync_q    (sync_q),
  .cfg_flat  (cfg_flat),
  .latch_q   (latch_q),
  .data_wr   (data_wr)
);

// File: tb/pin_mux_port_test.sv
`timescale 1ns/1ps
module pin_mux_port_test;

  localparam logic [15:0] AO0 = 16'hA5A5, AE0 = 16'hFFFF;
  localparam logic [15:0] AO1 = 16'h0F0F, AE1 = 16'h00FF;
  localparam logic [15:0] AO2 = 16'h3333, AE2 = 16'hF0F0;

  // {byte offset, write data} for the 16-pin instance
  localparam logic [39:0] VEC [8] = '{
    40'h08_0000_5A5A, 40'h00_1111_1111, 40'h04_4321_0F32, 40'h0C_FFFF_FFFF,
    40'h08_FFFF_0000, 40'h00_0000_0000, 40'h04_1111_1111, 40'h00_2345_6789
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_w = 1'b0, sel_n = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_w, rd_n;
  logic [15:0] pin_in_w = 16'hC3A6;
  logic [5:0]  pin_in_n = 6'h2D;
  logic [47:0] alt_o_w, alt_e_w;
  logic [15:0] pad_out_w, pad_oe_w;
  logic [5:0]  alt_o_n = 6'h2A, alt_e_n = 6'h3F;
  logic [5:0]  pad_out_n, pad_oe_n;

  int n_checks = 0;
  int n_fail = 0;

  logic [3:0]  m_cfg [16];
  logic [15:0] m_lat;

  assign alt_o_w = {AO2, AO1, AO0};
  assign alt_e_w = {AE2, AE1, AE0};

  always #2 clk = ~clk;

  pin_mux_port #(.NUM_PINS(16), .NUM_ALT(3), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_w), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_w), .pad_in(pin_in_w), .alt_out(alt_o_w),
    .alt_oe(alt_e_w), .pad_out(pad_out_w), .pad_oe(pad_oe_w)
  );

  pin_mux_port #(.NUM_PINS(6), .NUM_ALT(1), .ADDR_W(8)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_n), .pad_in(pin_in_n), .alt_out(alt_o_n),
    .alt_oe(alt_e_n), .pad_out(pad_out_n), .pad_oe(pad_oe_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input bit narrow, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_w = !narrow; sel_n = narrow; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    sel_w = 1'b0; sel_n = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic read_check(input bit narrow, input logic [7:0] a, input logic [31:0] exp,
                            input string req);
    bus_addr = a;
    #0.5;
    check(req, narrow ? rd_n : rd_w, exp);
  endtask

  // Expected register contents of the 16-pin instance, from R2, R6, R8, R10
  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] r = '0;
    for (int p = 0; p < 16; p++) begin
      if (a == 8'h00 && p < 8)  r[4*p +: 4] = m_cfg[p];
      if (a == 8'h04 && p >= 8) r[4*(p-8) +: 4] = m_cfg[p];
      if (a == 8'h08) r[p] = (m_cfg[p] == 4'h1) ? m_lat[p] : pin_in_w[p];
    end
    return r;
  endfunction

  // Expected pad outputs from R3, R4, R5
  task automatic model_pads(output logic [15:0] o, output logic [15:0] e);
    o = '0; e = '0;
    for (int p = 0; p < 16; p++) begin
      case (m_cfg[p])
        4'h1: begin o[p] = m_lat[p]; e[p] = 1'b1; end
        4'h2: begin o[p] = AO0[p];   e[p] = AE0[p]; end
        4'h3: begin o[p] = AO1[p];   e[p] = AE1[p]; end
        4'h4: begin o[p] = AO2[p];   e[p] = AE2[p]; end
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] eo, ee;
    for (int p = 0; p < 16; p++) m_cfg[p] = 4'h0;
    m_lat = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    read_check(0, 8'h00, 32'h0, "R1 cfg0");
    read_check(0, 8'h04, 32'h0, "R1 cfg1");
    check("R1 oe wide", {16'h0, pad_oe_w}, 32'h0);
    check("R1 out wide", {16'h0, pad_out_w}, 32'h0);
    check("R1 oe narrow", {26'h0, pad_oe_n}, 32'h0);
    read_check(1, 8'h00, 32'h0, "R1 cfg narrow");
    @(negedge clk); @(negedge clk);
    read_check(0, 8'h08, 32'h0000_C3A6, "R8 pads after reset");

    // Vector walk on the 16-pin instance: R2 R4 R5 R6 R8 R10
    for (int i = 0; i < 8; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      a = VEC[i][39:32];
      d = VEC[i][31:0];
      bus_write(0, a, d);
      if (a == 8'h00) for (int p = 0; p < 8; p++) m_cfg[p] = d[4*p +: 4];
      if (a == 8'h04) for (int p = 8; p < 16; p++) m_cfg[p] = d[4*(p-8) +: 4];
      if (a == 8'h08) m_lat = d[15:0];
      read_check(0, a, model_read(a), (a == 8'h0C) ? "R10 unmapped" :
                                      (a == 8'h08) ? "R8 data" : "R2 R6 cfg");
      read_check(0, 8'h08, model_read(8'h08), "R8 data after step");
      model_pads(eo, ee);
      check("R5 R4 pad_oe", {16'h0, pad_oe_w}, {16'h0, ee});
      check("R5 R4 pad_out", {16'h0, pad_out_w}, {16'h0, eo});
    end

    // R9: two-edge synchroniser latency
    bus_write(0, 8'h00, 32'h0);
    bus_write(0, 8'h04, 32'h0);
    @(negedge clk);
    pin_in_w = 16'h1234;
    read_check(0, 8'h08, 32'h0000_C3A6, "R9 before edge");
    @(negedge clk);
    read_check(0, 8'h08, 32'h0000_C3A6, "R9 after one edge");
    @(negedge clk);
    read_check(0, 8'h08, 32'h0000_1234, "R9 after two edges");

    // R7: preload latch while input, then switch to output
    bus_write(1, 8'h04, 32'h0000_0002);
    check("R7 input holds oe low", {26'h0, pad_oe_n}, 32'h0);
    read_check(1, 8'h04, 32'h0000_002D, "R8 input pins read pad");
    bus_write(1, 8'h00, 32'h0000_0010);
    check("R7 oe rises", {26'h0, pad_oe_n}, 32'h02);
    check("R7 preloaded level", {26'h0, pad_out_n}, 32'h02);
    read_check(1, 8'h04, 32'h0000_002F, "R8 output pin reads latch");

    // R10: unmapped offset in narrow layout
    bus_write(1, 8'h08, 32'hFFFF_FFFF);
    read_check(1, 8'h08, 32'h0, "R10 narrow unmapped read");
    read_check(1, 8'h00, 32'h0000_0010, "R10 cfg untouched");
    read_check(1, 8'h04, 32'h0000_002F, "R10 latch untouched");

    // R11: fields of absent pins
    bus_write(1, 8'h00, 32'hFFFF_FFFF);
    read_check(1, 8'h00, 32'h00FF_FFFF, "R11 absent fields read zero");
    check("R5 code F floats", {26'h0, pad_oe_n}, 32'h0);
    bus_write(1, 8'h04, 32'hFFFF_FFFF);
    read_check(1, 8'h04, 32'h0000_002D, "R11 absent data bits zero");

    // R5: narrow alternate routing and unused code 3
    bus_write(1, 8'h00, 32'h0022_2222);
    check("R5 alt oe", {26'h0, pad_oe_n}, 32'h3F);
    check("R5 alt out", {26'h0, pad_out_n}, 32'h2A);
    bus_write(1, 8'h00, 32'h0033_3333);
    check("R5 unused code", {26'h0, pad_oe_n}, 32'h0);

    finish_run();
  end

endmodule